// File: doc/BRIEF.md
# Master clock ratio mode detector

This block counts master clock cycles between successive rising edges of the frame (left/right) clock. From that count it works out which clock ratio the converter is running at and selects between two operating regimes. A base rate regime covers ratios of 256, 384 and 512 master clocks per frame. A high rate regime covers ratios of 128 and 192, which allows sample rates up to 100 kHz.

The selected regime goes straight to the downstream datapath as two settings:

- the sample-and-hold replication factor, 32 in base rate and 16 in high rate;
- the modulator bit rate as a multiple of the sample rate, 128 in base rate and 64 in high rate.

A ratio is accepted only when two back-to-back frames measure the same length. A frame of any other length raises an error flag and leaves the last accepted setting in place.

The frame clock is asynchronous to the master clock. It passes through a two-stage synchronizer before its rising edges are detected. The block has no software access. It runs continuously from reset.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is asserted and right after it is released, `rate_hi`=0, `ratio_code`=0, `ratio_valid`=0, `ratio_err`=0, `hold_factor`=32 and `mod_osr`=128.
- R2: A confirmed frame length of 256, 384 or 512 master clocks sets `rate_hi`=0 and `ratio_code` to 2, 3 or 4 respectively.
- R3: A confirmed frame length of 128 or 192 master clocks sets `rate_hi`=1 and `ratio_code` to 0 or 1 respectively.
- R4: `hold_factor` is 16 and `mod_osr` is 64 when `rate_hi`=1. They are 32 and 128 when `rate_hi`=0.
- R5: A length counts as confirmed only when two consecutive frame measurements are equal. The first rising edge after reset only starts timing, so `ratio_valid` rises no earlier than the third frame-clock rising edge. Once set, it stays high until reset.
- R6: A measured frame length other than the five legal values sets `ratio_err`=1. It leaves `rate_hi`, `ratio_code` and `ratio_valid` unchanged.
- R7: `ratio_err` returns to 0 only when a legal length is next confirmed.
- R8: A detection update appears at the third master clock rising edge that samples the frame clock high after it was low.
- R9: Only rising edges of the frame clock are timed. The high/low duty cycle of the frame clock does not affect the result.
- R10: The period counter saturates instead of wrapping. A frame longer than 1023 master clocks (with the default 10-bit counter) is reported as an error and is never mistaken for a short legal ratio.
- R11: A single frame of a different legal length, between frames of the confirmed length, leaves `rate_hi` and `ratio_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock, asynchronous to `mclk` |
| rate_hi | output | 1 | 1 = high rate regime, 0 = base rate regime |
| ratio_code | output | 3 | Confirmed ratio: 0=128, 1=192, 2=256, 3=384, 4=512 |
| ratio_valid | output | 1 | A ratio has been confirmed since reset |
| ratio_err | output | 1 | The last unsupported measurement has not yet been followed by a confirmed ratio |
| hold_factor | output | 6 | Sample-and-hold replication for the datapath (16 or 32) |
| mod_osr | output | 8 | Modulator bit rate in multiples of the sample rate (64 or 128) |

## Verification
The bench targets five design errors:

- **Single-frame confirmation.** A lone 256-clock frame is inserted between 192-clock frames. A design that accepts one measurement would briefly switch to base rate.
- **Counter wrap.** A 1152-clock frame follows 128-clock frames. A design whose counter wraps would read it as 128, confirm it and clear the error rather than raise it.
- **Edge timing.** The frame clock runs with 10 % and 94 % duty cycles. A design that times both edges, or the wrong edge, would measure the wrong length.
- **Unsupported length.** 300-clock frames are driven. A design that overwrote the mode on such a frame would lose the last good setting.
- **Pipeline latency.** The exact edge at which the first confirmation appears is checked. This catches a synchronizer with a missing or extra stage.

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter int CNT_W = 10
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck,
  output logic       rate_hi,
  output logic [2:0] ratio_code,
  output logic       ratio_valid,
  output logic       ratio_err,
  output logic [5:0] hold_factor,
  output logic [7:0] mod_osr
);

  localparam int PW = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PW-1:0] LEN_128 = PW'(128);
  localparam logic [PW-1:0] LEN_192 = PW'(192);
  localparam logic [PW-1:0] LEN_256 = PW'(256);
  localparam logic [PW-1:0] LEN_384 = PW'(384);
  localparam logic [PW-1:0] LEN_512 = PW'(512);

  logic [2:0]       lr_sync;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic [PW-1:0]    last_len;
  logic             have_last;
  logic [PW-1:0]    len;
  logic             legal;
  logic             hi_c;
  logic [2:0]       code_c;

  wire rise = lr_sync[1] & ~lr_sync[2];
  assign len = {1'b0, cnt} + PW'(1);

  always_comb begin
    legal  = 1'b1;
    hi_c   = 1'b0;
    code_c = 3'd0;
    case (len)
      LEN_128: begin hi_c = 1'b1; code_c = 3'd0; end
      LEN_192: begin hi_c = 1'b1; code_c = 3'd1; end
      LEN_256: code_c = 3'd2;
      LEN_384: code_c = 3'd3;
      LEN_512: code_c = 3'd4;
      default: legal = 1'b0;
    endcase
  end

  wire measure = rise & armed;
  wire confirm = measure & legal & have_last & (len == last_len);
  wire bad     = measure & ~legal;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_sync   <= '0;
      cnt       <= '0;
      armed     <= 1'b0;
      last_len  <= '0;
      have_last <= 1'b0;
    end else begin
      lr_sync <= {lr_sync[1:0], lrck};
      if (rise)
        cnt <= '0;
      else if (cnt != CNT_MAX)
        cnt <= cnt + CNT_ONE;
      if (rise)
        armed <= 1'b1;
      if (measure) begin
        last_len  <= len;
        have_last <= 1'b1;
      end
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      rate_hi     <= 1'b0;
      ratio_code  <= 3'd0;
      ratio_valid <= 1'b0;
      ratio_err   <= 1'b0;
    end else if (confirm) begin
      rate_hi     <= hi_c;
      ratio_code  <= code_c;
      ratio_valid <= 1'b1;
      ratio_err   <= 1'b0;
    end else if (bad) begin
      ratio_err   <= 1'b1;
    end
  end

  assign hold_factor = rate_hi ? 6'd16 : 6'd32;
  assign mod_osr     = rate_hi ? 8'd64 : 8'd128;

endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic       rate_hi,
  input logic [2:0] ratio_code,
  input logic       ratio_valid,
  input logic       ratio_err,
  input logic [5:0] hold_factor,
  input logic [7:0] mod_osr
);

  // R5
  valid_sticky_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_valid |=> ratio_valid);

  // R6
  err_keeps_mode_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(ratio_err) |-> ($stable(rate_hi) && $stable(ratio_code) && $stable(ratio_valid)));

  // R7
  err_clear_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $fell(ratio_err) |-> ratio_valid);

  // R4
  rate_pair_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    mod_osr == {hold_factor, 2'b00});

  // R2
  code_range_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_code <= 3'd4);

  // R3
  mode_code_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_valid |-> (rate_hi == (ratio_code < 3'd2)));

  // R1
  idle_state_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !ratio_valid |-> (ratio_code == 3'd0 && !rate_hi));

endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
  .mclk(mclk),
  .rst_n(rst_n),
  .rate_hi(rate_hi),
  .ratio_code(ratio_code),
  .ratio_valid(ratio_valid),
  .ratio_err(ratio_err),
  .hold_factor(hold_factor),
  .mod_osr(mod_osr)
);

// File: tb/mclk_ratio_detect_test.sv
`timescale 1ns/1ps
module mclk_ratio_detect_test;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic       rate_hi;
  logic [2:0] ratio_code;
  logic       ratio_valid;
  logic       ratio_err;
  logic [5:0] hold_factor;
  logic [7:0] mod_osr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 mclk = ~mclk;

  mclk_ratio_detect uut (
    .mclk(mclk), .rst_n(rst_n), .lrck(lrck),
    .rate_hi(rate_hi), .ratio_code(ratio_code), .ratio_valid(ratio_valid),
    .ratio_err(ratio_err), .hold_factor(hold_factor), .mod_osr(mod_osr)
  );

  // reference model state
  bit mq[$] = '{0, 0, 0};
  int edge_n = 0, last_rise = 0, last_p = 0;
  bit seen = 0, has_last = 0;
  bit e_hi = 0, e_valid = 0, e_err = 0;
  int e_code = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(bit v);
    int p;
    bit ok, hi;
    int code;
    if (!rst_n) begin
      mq = '{0, 0, 0};
      edge_n = 0; last_rise = 0; last_p = 0;
      seen = 0; has_last = 0;
      e_hi = 0; e_code = 0; e_valid = 0; e_err = 0;
      return;
    end
    mq.push_back(v);
    edge_n++;
    if (mq[1] && !mq[0]) begin
      if (seen) begin
        p = edge_n - last_rise;
        ok = 1; hi = 0; code = 0;
        case (p)
          128: begin hi = 1; code = 0; end
          192: begin hi = 1; code = 1; end
          256: code = 2;
          384: code = 3;
          512: code = 4;
          default: ok = 0;
        endcase
        if (ok && has_last && p == last_p) begin
          e_hi = hi; e_code = code; e_valid = 1; e_err = 0;
        end else if (!ok) begin
          e_err = 1;
        end
        last_p = p;
        has_last = 1;
      end
      last_rise = edge_n;
      seen = 1;
    end
    void'(mq.pop_front());
  endtask

  task automatic tick(bit v);
    @(negedge mclk);
    lrck = v;
    @(posedge mclk);
    model_step(v);
    #2;
    chk("R5 valid", ratio_valid, e_valid);
    chk("R2 rate_hi", rate_hi, e_hi);
    chk("R3 code", ratio_code, e_code);
    chk("R6 err", ratio_err, e_err);
    chk("R4 hold", hold_factor, e_hi ? 16 : 32);
    chk("R4 osr", mod_osr, e_hi ? 64 : 128);
  endtask

  task automatic frame(int n, int hi);
    for (int i = 0; i < n; i++) tick(i < hi);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick(0);
    chk("R1 valid in reset", ratio_valid, 0);
    @(negedge mclk);
    rst_n = 1'b1;
    tick(0);
    chk("R1 valid", ratio_valid, 0);
    chk("R1 code", ratio_code, 0);
    chk("R1 rate_hi", rate_hi, 0);
    chk("R1 err", ratio_err, 0);
    chk("R1 hold", hold_factor, 32);
    chk("R1 osr", mod_osr, 128);

    frame(256, 128);
    frame(256, 128);
    chk("R5 one measurement only", ratio_valid, 0);
    tick(1);
    chk("R8 edge k", ratio_valid, 0);
    tick(1);
    chk("R8 edge k+1", ratio_valid, 0);
    tick(1);
    chk("R8 edge k+2", ratio_valid, 1);
    chk("R2 code 256", ratio_code, 2);
    for (int i = 3; i < 256; i++) tick(i < 128);
    frame(256, 128);

    for (int i = 0; i < 3; i++) frame(384, 192);
    chk("R2 code 384", ratio_code, 3);
    chk("R2 rate_hi 384", rate_hi, 0);

    for (int i = 0; i < 3; i++) frame(512, 51);
    chk("R9 short duty 512", ratio_code, 4);

    for (int i = 0; i < 3; i++) frame(128, 120);
    chk("R9 long duty 128", ratio_code, 0);
    chk("R3 rate_hi 128", rate_hi, 1);
    chk("R4 hold high", hold_factor, 16);
    chk("R4 osr high", mod_osr, 64);

    for (int i = 0; i < 3; i++) frame(192, 96);
    chk("R3 code 192", ratio_code, 1);

    frame(256, 128);
    frame(192, 96);
    chk("R11 code kept", ratio_code, 1);
    chk("R11 rate kept", rate_hi, 1);
    frame(192, 96);
    frame(192, 96);

    for (int i = 0; i < 3; i++) frame(300, 150);
    chk("R6 err set", ratio_err, 1);
    chk("R6 valid kept", ratio_valid, 1);
    chk("R6 code kept", ratio_code, 1);
    chk("R6 rate kept", rate_hi, 1);

    for (int i = 0; i < 3; i++) frame(128, 64);
    chk("R7 err cleared", ratio_err, 0);
    chk("R7 code 128", ratio_code, 0);

    frame(1152, 576);
    frame(128, 64);
    chk("R10 long frame err", ratio_err, 1);
    chk("R10 code kept", ratio_code, 0);
    frame(128, 64);
    frame(128, 64);
    chk("R7 err cleared again", ratio_err, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule